// File: doc/BRIEF.md
# Triggered Hit Memory with Token-Ring Readout

This block is the event store of a 64-channel discriminator front end. On each trigger strobe it captures one event word: a fixed header byte, the current bunch-crossing number and the two-bit code of every channel. No zero suppression is applied, so a trigger with every channel quiet is stored like any other. Up to 128 events are held. The bunch-crossing number comes from a 24-bit counter that advances on every bunch clock.

Readout is gated by a token that travels around a daisy-chained ring of up to 100 chips. When the token arrives, the chip shifts its stored events out on a single serial line, oldest first, with a valid flag. It then passes the token on and empties its memory. A chip with nothing stored passes the token on at once. The discriminators and the physical link are outside this block.

Top module: `hit_event_store`

## Requirements
- R1: While reset is low and on the first edge after it, memFull, serialValid and tokenOut are 0.
- R2: The bunch-crossing counter is 0 after reset, advances by one on every clock edge and wraps at 2^24. The stored number is the counter value at the clock edge that samples the trigger.
- R3: Each accepted trigger stores a 160-bit word laid out as {header 8'hA5, bunch-crossing[23:0], channel 63 code, ..., channel 0 code}. Channel i occupies hitCodes[2i+1:2i]. All channels are stored even when every code is 0.
- R4: The clock edge that accepts the token sets serialValid high and puts bit 159 of the oldest event on serialOut. One bit follows per clock, MSB first. Events follow in write order with no gap.
- R5: tokenOut is a one-cycle pulse. It rises at the edge after the last bit has been shown, with serialValid falling at that same edge. With an empty memory it rises at the edge that samples tokenIn.
- R6: memFull rises at the edge that stores the 128th event. Triggers arriving while the memory is full are ignored.
- R7: When readout completes, the memory is emptied and memFull falls. The next trigger is written at address 0, so a later readout returns only events stored after it.
- R8: During readout, both trigger and tokenIn are ignored. A trigger in the same cycle as an accepted token is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitCodes | input | 128 | Discriminator codes, channel i at bits [2i+1:2i] |
| trigger | input | 1 | Store strobe, sampled at each rising edge |
| tokenIn | input | 1 | Readout token from the previous chip in the ring |
| serialOut | output | 1 | Serial event data, MSB first |
| serialValid | output | 1 | High while serialOut carries event bits |
| memFull | output | 1 | High when 128 events are stored |
| tokenOut | output | 1 | One-cycle token pulse to the next chip |

## Verification
A trigger is stored at the edge that samples it, and memFull follows at that same edge. The first serial bit appears at the edge that accepts the token. The last bit is shown 160·N − 1 edges later, and tokenOut rises at the edge after that. With an empty memory, tokenOut rises at the token edge itself. The bench drives inputs on the falling edge and samples on the following falling edge, so each result is read exactly one register stage after its cause. The bench keeps its own bunch-crossing count and builds the expected words from the requirements. It compares each shifted event as a whole and checks the token pulse and memFull at their due edge and again one cycle later.

// File: rtl/hitmem_pkg.sv
package hitmem_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store the assembled event word
    logic loadEn;   // load an event into the output shifter
    logic shiftEn;  // advance the output shifter by one bit
  } memStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } rdState_t;

endpackage

// File: rtl/hitmem_ctrl.sv
module hitmem_ctrl
  import hitmem_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int BCID_W = 24,
  parameter int EV_W   = 160
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     trigger,
  input  logic                     tokenIn,
  output memStrobe_t               str,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [BCID_W-1:0]        bcid,
  output logic                     serialValid,
  output logic                     memFull,
  output logic                     tokenOut
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int BIT_W  = $clog2(EV_W);

  rdState_t            state;
  logic [CNT_W-1:0]    wrPtr;
  logic [ADDR_W-1:0]   evIdx;
  logic [BIT_W-1:0]    bitIdx;
  logic [BCID_W-1:0]   bcidQ;
  logic                tokenQ;

  logic isIdle, full, empty, lastBit, lastEvent;

  always_comb begin
    isIdle    = (state == ST_IDLE);
    full      = (wrPtr == CNT_W'(DEPTH));
    empty     = (wrPtr == '0);
    lastBit   = (bitIdx == BIT_W'(EV_W - 1));
    lastEvent = (CNT_W'(evIdx) + CNT_W'(1) == wrPtr);
    str.wrEn    = isIdle && trigger && !tokenIn && !full;
    str.loadEn  = (isIdle && tokenIn && !empty) ||
                  (!isIdle && lastBit && !lastEvent);
    str.shiftEn = !isIdle;
    rdAddr      = isIdle ? '0 : evIdx + ADDR_W'(1);
    wrAddr      = ADDR_W'(wrPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrPtr  <= '0;
      evIdx  <= '0;
      bitIdx <= '0;
      bcidQ  <= '0;
      tokenQ <= 1'b0;
    end else begin
      bcidQ  <= bcidQ + BCID_W'(1);
      tokenQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tokenIn) begin
            if (empty) begin
              tokenQ <= 1'b1;
            end else begin
              state  <= ST_READ;
              evIdx  <= '0;
              bitIdx <= '0;
            end
          end else if (str.wrEn) begin
            wrPtr <= wrPtr + CNT_W'(1);
          end
        end
        ST_READ: begin
          if (lastBit) begin
            bitIdx <= '0;
            if (lastEvent) begin
              state  <= ST_IDLE;
              tokenQ <= 1'b1;
              wrPtr  <= '0;
            end else begin
              evIdx <= evIdx + ADDR_W'(1);
            end
          end else begin
            bitIdx <= bitIdx + BIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bcid        = bcidQ;
  assign serialValid = !isIdle;
  assign memFull     = full;
  assign tokenOut    = tokenQ;

  // R2: counter steps by one each bunch clock
  a_r2_bcid_step: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (bcidQ == $past(bcidQ) + BCID_W'(1)));

  // R6: a full memory stays full until a token arrives
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && isIdle && !tokenIn) |=> full);

  // R6: occupancy never passes the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= CNT_W'(DEPTH));

  // R5: token out is a single-cycle pulse
  a_r5_token_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tokenQ |=> !tokenQ);

  // R7: token leaves with an empty memory and an idle shifter
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rstN)
    tokenQ |-> (wrPtr == '0 && isIdle));

  // R8: no write while reading out
  a_r8_no_write_reading: assert property (@(posedge clk) disable iff (!rstN)
    !isIdle |=> (wrPtr == $past(wrPtr) || wrPtr == '0));

endmodule

// File: rtl/hitmem_dpath.sv
module hitmem_dpath
  import hitmem_pkg::*;
#(
  parameter int          NUM_CH = 64,
  parameter int          CODE_W = 2,
  parameter int          BCID_W = 24,
  parameter int          HDR_W  = 8,
  parameter int          DEPTH  = 128,
  parameter logic [7:0]  HEADER = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  memStrobe_t                 str,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [NUM_CH*CODE_W-1:0]   hitCodes,
  input  logic [BCID_W-1:0]          bcid,
  output logic                       serialOut
);

  localparam int HIT_W = NUM_CH * CODE_W;
  localparam int EV_W  = HDR_W + BCID_W + HIT_W;

  logic [EV_W-1:0] mem [DEPTH];
  logic [EV_W-1:0] shiftReg;
  logic [EV_W-1:0] eventWord;
  logic [HIT_W-1:0] chanField;

  // channel fields, highest channel in the most significant slot
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chanField[ch*CODE_W +: CODE_W] = hitCodes[ch*CODE_W +: CODE_W];
  end

  assign eventWord = {HDR_W'(HEADER), bcid, chanField};

  always_ff @(posedge clk) begin
    if (str.wrEn) mem[wrAddr] <= eventWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           shiftReg <= '0;
    else if (str.loadEn) shiftReg <= mem[rdAddr];
    else if (str.shiftEn) shiftReg <= {shiftReg[EV_W-2:0], 1'b0};
  end

  assign serialOut = shiftReg[EV_W-1];

  // R4: bits move towards the output one place per clock
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    (str.shiftEn && !str.loadEn) |=> (shiftReg[EV_W-1] == $past(shiftReg[EV_W-2])));

endmodule

// File: rtl/hit_event_store.sv
module hit_event_store
  import hitmem_pkg::*;
#(
  parameter int         NUM_CH = 64,
  parameter int         CODE_W = 2,
  parameter int         BCID_W = 24,
  parameter int         HDR_W  = 8,
  parameter int         DEPTH  = 128,
  parameter logic [7:0] HEADER = 8'hA5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*CODE_W-1:0] hitCodes,
  input  logic                     trigger,
  input  logic                     tokenIn,
  output logic                     serialOut,
  output logic                     serialValid,
  output logic                     memFull,
  output logic                     tokenOut
);

  localparam int EV_W   = HDR_W + BCID_W + NUM_CH * CODE_W;
  localparam int ADDR_W = $clog2(DEPTH);

  memStrobe_t        str;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [BCID_W-1:0] bcid;

  hitmem_ctrl #(.DEPTH(DEPTH), .BCID_W(BCID_W), .EV_W(EV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .tokenIn(tokenIn),
    .str(str), .wrAddr(wrAddr), .rdAddr(rdAddr), .bcid(bcid),
    .serialValid(serialValid), .memFull(memFull), .tokenOut(tokenOut)
  );

  hitmem_dpath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .BCID_W(BCID_W),
                 .HDR_W(HDR_W), .DEPTH(DEPTH), .HEADER(HEADER)) dpath_i (
    .clk(clk), .rstN(rstN), .str(str), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .hitCodes(hitCodes), .bcid(bcid), .serialOut(serialOut)
  );

endmodule

// File: tb/hit_event_store_tb.sv
`timescale 1ns/1ps
module hit_event_store_tb_top;

  localparam int DEPTH = 128;
  localparam int EV_W  = 160;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [127:0] hitCodes = '0;
  logic trigger = 1'b0;
  logic tokenIn = 1'b0;
  logic serialOut, serialValid, memFull, tokenOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [23:0]     tbBcid;
  logic [EV_W-1:0] expQ [DEPTH];
  int              expN = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) tbBcid <= '0;
    else       tbBcid <= tbBcid + 24'd1;
  end

  hit_event_store dut_i (
    .clk(clk), .rstN(rstN), .hitCodes(hitCodes), .trigger(trigger),
    .tokenIn(tokenIn), .serialOut(serialOut), .serialValid(serialValid),
    .memFull(memFull), .tokenOut(tokenOut)
  );

  task automatic check(input bit ok, input string req,
                       input logic [EV_W-1:0] act, input logic [EV_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pattern(input int k);
    logic [31:0] a;
    a = 32'(k) * 32'h9E3779B1 + 32'h1234;
    return {a, ~a, a ^ 32'h5A5A5A5A, {a[15:0], a[31:16]}};
  endfunction

  // drive one trigger; record it if the requirements say it is stored
  task automatic doTrigger(input logic [127:0] codes);
    hitCodes = codes;
    trigger  = 1'b1;
    if (expN < DEPTH) begin
      expQ[expN] = {8'hA5, tbBcid, codes};
      expN++;
    end
    @(negedge clk);
    trigger = 1'b0;
  endtask

  // pass the token in and check the whole readout
  task automatic readAll(input bit inject);
    logic [EV_W-1:0] got;
    bit vOk;
    tokenIn = 1'b1;
    @(negedge clk);
    tokenIn = 1'b0;
    if (expN == 0) begin
      check(tokenOut == 1'b1 && serialValid == 1'b0, "R5 empty token pass",
            {tokenOut, serialValid}, 2'b10);
    end else begin
      for (int e = 0; e < expN; e++) begin
        vOk = 1'b1;
        got = '0;
        for (int b = 0; b < EV_W; b++) begin
          if (inject && e == 0 && b == 5) begin trigger = 1'b1; tokenIn = 1'b1; end
          if (inject && e == 0 && b == 6) begin trigger = 1'b0; tokenIn = 1'b0; end
          got = {got[EV_W-2:0], serialOut};
          if (!serialValid || tokenOut) vOk = 1'b0;
          @(negedge clk);
        end
        check(vOk && got == expQ[e], "R2 R3 R4 event word", got, expQ[e]);
      end
      check(tokenOut == 1'b1 && serialValid == 1'b0, "R5 token after last bit",
            {tokenOut, serialValid}, 2'b10);
      check(memFull == 1'b0, "R7 full cleared", memFull, 0);
    end
    @(negedge clk);
    check(tokenOut == 1'b0, "R5 token pulse width", tokenOut, 0);
    expN = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!memFull && !serialValid && !tokenOut, "R1 in reset",
          {memFull, serialValid, tokenOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memFull && !serialValid && !tokenOut, "R1 after reset",
          {memFull, serialValid, tokenOut}, 0);
  endtask

  task automatic testEmptyToken();
    readAll(1'b0);
  endtask

  task automatic testPatterns();
    doTrigger('0);                       // R3 quiet event still stored
    repeat (37) @(negedge clk);          // R2 spacing between crossings
    doTrigger('1);
    doTrigger({64{2'b10}});
    repeat (3) @(negedge clk);
    doTrigger(pattern(7));
    readAll(1'b0);
  endtask

  task automatic testTokenWithTrigger();
    hitCodes = pattern(3);
    trigger  = 1'b1;
    tokenIn  = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    tokenIn = 1'b0;
    check(tokenOut == 1'b1, "R8 token with trigger passes empty", tokenOut, 1);
    @(negedge clk);
    readAll(1'b0);                       // R8 nothing was stored
  endtask

  task automatic testFill();
    for (int k = 0; k < DEPTH; k++) begin
      doTrigger(pattern(k + 100));
      if (k == DEPTH - 2)
        check(memFull == 1'b0, "R6 not full at 127", memFull, 0);
    end
    check(memFull == 1'b1, "R6 full at 128", memFull, 1);
    doTrigger(pattern(999));             // R6 ignored, model keeps 128
    check(memFull == 1'b1, "R6 still full", memFull, 1);
    readAll(1'b1);                       // R8 trigger and token injected
    readAll(1'b0);                       // R8 injected trigger left nothing
  endtask

  task automatic testRestart();
    doTrigger(pattern(55));
    check(memFull == 1'b0, "R7 one event not full", memFull, 0);
    readAll(1'b0);                       // R7 only the new event
  endtask

  initial begin
    testReset();
    testEmptyToken();
    testPatterns();
    testTokenWithTrigger();
    testFill();
    testRestart();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule